// File: doc/BRIEF.md
# Four-Way Parallel 2-Bit Lag Correlator

The block correlates two streams of 2-bit quantized samples over a run of lags. Each input port carries one 8-bit word per clock that packs four consecutive samples, so the block handles four samples per stream every clock. For every lag it forms the four sample-pair products of one word period, adds them into a single small sum and adds that sum into one accumulator for the lag. A host sets the integration length in clocks, pulses a start input, waits for a done flag and reads the lag results one at a time through an address and data port. The host can select single-shot or back-to-back integration. An auto-correlation mode feeds the X stream into both sides of the products.

Lag k accumulates x(i)·y(i+k) over all samples i in the integration. Internally the X word is delayed by NLAG/4 + 1 clocks and the Y words are kept in a short word-aligned history, so a product can reach a Y sample that lies in a later word than its X sample. A cascade port carries the X stream delayed by NLAG samples, plus the Y stream. A second instance fed from it computes lags NLAG to 2·NLAG−1.

Control is a two-state machine. ST_IDLE holds the accumulators at zero and moves to ST_RUN on start. ST_RUN accumulates every clock. At the terminal count it dumps the results. It then returns to ST_IDLE when continuous is low, or stays in ST_RUN when continuous is high.

Top module: `quad_lag_correlator`

## Requirements
- R1: A sample code c (0..3) has the weight 2c−3, giving −3, −1, +1 or +3. Within a word, sample j (j = 0 is the earliest) occupies bits [2j+1:2j].
- R2: After an integration, the result for lag k equals the sum of x(s)·y(s+k) over the 4·len sample positions s. The positions start at the X word sampled L+1 clocks (L = NLAG/4) before the first accumulating clock, which is the clock after the one where start is sampled.
- R3: Start is accepted only in ST_IDLE and moves the machine to ST_RUN (busy high). Start is ignored in ST_RUN. The dump happens on the int_len-th clock after the clock where start is sampled, and done is high from the following cycle. An int_len of 0 behaves as 1.
- R4: The readout buffer addressed by rd_lag changes only on a dump, and keeps its values while new data streams in.
- R5: With continuous high, the next integration begins on the clock right after a dump and misses no sample. Its result covers the following int_len clocks.
- R6: Done is set by a dump. It stays high until ack is sampled and then clears on the next clock, unless a dump occurs on that same clock, in which case done stays high.
- R7: With auto_mode high, y_word is ignored and the X word is used as the Y stream. This applies to the results and to cas_y.
- R8: After each clock edge e, cas_x holds the X word sampled at edge e−L and cas_y holds the Y-stream word sampled at edge e. A second instance fed from these ports and started on the same clock yields lag NLAG+k as its lag k.
- R9: After reset the machine is in ST_IDLE, busy and done are low and every readout entry is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| x_word | input | 8 | Four packed X samples, earliest in bits [1:0] |
| y_word | input | 8 | Four packed Y samples, earliest in bits [1:0] |
| auto_mode | input | 1 | 1: correlate X with itself |
| int_len | input | LEN_W | Integration length in clocks |
| start | input | 1 | Begin integration (accepted in ST_IDLE) |
| continuous | input | 1 | 1: start the next integration right after each dump |
| ack | input | 1 | Clears done |
| rd_lag | input | $clog2(NLAG) | Lag index to read |
| rd_data | output | ACC_W | Signed readout value of lag rd_lag |
| busy | output | 1 | High in ST_RUN |
| done | output | 1 | Results ready, held until ack |
| cas_x | output | 8 | X stream delayed NLAG samples for the next instance |
| cas_y | output | 8 | Y stream for the next instance |

## Verification
On every cycle the assertions check the control rules. Start from ST_IDLE always leads to ST_RUN, done holds until ack and clears after an ack without a dump, and done only rises out of a running integration. They also check that the readout stays frozen between dumps and that auto mode routes X to cas_y. The numerical results can only be shown by the bench scenarios, which compare every lag against an independent sample-level model. These include the way lag windows cross word boundaries, the exact dump clock, back-to-back integrations without a lost sample, and the cascaded lag extension through a second instance.

// File: rtl/qlc_pkg.sv
package qlc_pkg;
    localparam int SMP_W  = 2;
    localparam int SPW    = 4;
    localparam int WORD_W = SMP_W * SPW;
    localparam int SUM_W  = 7;

    typedef enum logic {ST_IDLE, ST_RUN} qlc_state_t;

    function automatic logic signed [3:0] level(input logic [1:0] code);
        return $signed({1'b0, code, 1'b1}) - 4'sd4;
    endfunction
endpackage

// File: rtl/qlc_delay.sv
module qlc_delay #(
    parameter int L = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [qlc_pkg::WORD_W-1:0]       x_in,
    input  logic [qlc_pkg::WORD_W-1:0]       y_in,
    output logic [qlc_pkg::WORD_W-1:0]       xd,
    output logic [qlc_pkg::WORD_W*(L+1)-1:0] win,
    output logic [qlc_pkg::WORD_W-1:0]       cas_y
);
    import qlc_pkg::*;

    logic [WORD_W-1:0] xp [L+1];
    logic [WORD_W-1:0] yh [L+1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i <= L; i++) begin
                xp[i] <= '0;
                yh[i] <= '0;
            end
        end else begin
            xp[0] <= x_in;
            yh[0] <= y_in;
            for (int i = 1; i <= L; i++) begin
                xp[i] <= xp[i-1];
                yh[i] <= yh[i-1];
            end
        end
    end

    genvar w;
    generate
        for (w = 0; w <= L; w++) begin : g_win
            assign win[WORD_W*w +: WORD_W] = yh[L-w];
        end
    endgenerate

    assign xd    = xp[L];
    assign cas_y = yh[0];
endmodule

// File: rtl/qlc_lag_quad.sv
module qlc_lag_quad #(
    parameter int BASE  = 0,
    parameter int L     = 4,
    parameter int ACC_W = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             acc_en,
    input  logic                             dump,
    input  logic [qlc_pkg::WORD_W-1:0]       xd,
    input  logic [qlc_pkg::WORD_W*(L+1)-1:0] win,
    output logic [4*ACC_W-1:0]               res
);
    import qlc_pkg::*;

    genvar k;
    generate
        for (k = 0; k < SPW; k++) begin : g_lag
            logic signed [SUM_W-1:0] psum;
            logic signed [ACC_W-1:0] acc;
            logic signed [ACC_W-1:0] hold;

            always_comb begin
                psum = '0;
                for (int j = 0; j < SPW; j++) begin
                    psum = psum + SUM_W'(level(xd[SMP_W*j +: SMP_W]))
                                * SUM_W'(level(win[SMP_W*(j+BASE+k) +: SMP_W]));
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    acc  <= '0;
                    hold <= '0;
                end else if (dump) begin
                    hold <= acc + ACC_W'(psum);
                    acc  <= '0;
                end else if (acc_en) begin
                    acc  <= acc + ACC_W'(psum);
                end
            end

            assign res[ACC_W*k +: ACC_W] = hold;
        end
    endgenerate
endmodule

// File: rtl/qlc_ctrl.sv
module qlc_ctrl #(
    parameter int LEN_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             continuous,
    input  logic             ack,
    input  logic [LEN_W-1:0] int_len,
    output logic             acc_en,
    output logic             dump,
    output logic             busy,
    output logic             done
);
    import qlc_pkg::*;

    qlc_state_t       state, state_nx;
    logic [LEN_W-1:0] cnt;
    logic             term;

    assign term = ({1'b0, cnt} + 1'b1) >= {1'b0, int_len};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        acc_en   = 1'b0;
        dump     = 1'b0;
        busy     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start) state_nx = ST_RUN;
            end
            ST_RUN: begin
                acc_en = 1'b1;
                busy   = 1'b1;
                dump   = term;
                if (term && !continuous) state_nx = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            done <= 1'b0;
        end else begin
            if (state != ST_RUN || term) cnt <= '0;
            else                         cnt <= cnt + 1'b1;
            if (dump)     done <= 1'b1;
            else if (ack) done <= 1'b0;
        end
    end
endmodule

// File: rtl/quad_lag_correlator.sv
module quad_lag_correlator #(
    parameter int NLAG  = 16,
    parameter int ACC_W = 32,
    parameter int LEN_W = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [7:0]              x_word,
    input  logic [7:0]              y_word,
    input  logic                    auto_mode,
    input  logic [LEN_W-1:0]        int_len,
    input  logic                    start,
    input  logic                    continuous,
    input  logic                    ack,
    input  logic [$clog2(NLAG)-1:0] rd_lag,
    output logic [ACC_W-1:0]        rd_data,
    output logic                    busy,
    output logic                    done,
    output logic [7:0]              cas_x,
    output logic [7:0]              cas_y
);
    import qlc_pkg::*;

    localparam int L     = NLAG / SPW;
    localparam int WIN_W = WORD_W * (L + 1);

    logic [WORD_W-1:0]     y_src;
    logic [WORD_W-1:0]     xd;
    logic [WIN_W-1:0]      win;
    logic [NLAG*ACC_W-1:0] res_flat;
    logic                  acc_en;
    logic                  dump;

    assign y_src = auto_mode ? x_word : y_word;

    qlc_delay #(.L(L)) u_delay (
        .clk(clk), .rst_n(rst_n), .x_in(x_word), .y_in(y_src),
        .xd(xd), .win(win), .cas_y(cas_y)
    );

    qlc_ctrl #(.LEN_W(LEN_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .continuous(continuous),
        .ack(ack), .int_len(int_len), .acc_en(acc_en), .dump(dump),
        .busy(busy), .done(done)
    );

    genvar q;
    generate
        for (q = 0; q < L; q++) begin : g_quad
            qlc_lag_quad #(.BASE(SPW*q), .L(L), .ACC_W(ACC_W)) u_quad (
                .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .dump(dump),
                .xd(xd), .win(win),
                .res(res_flat[SPW*ACC_W*q +: SPW*ACC_W])
            );
        end
    endgenerate

    assign rd_data = res_flat[ACC_W*rd_lag +: ACC_W];
    assign cas_x   = xd;
endmodule

// File: rtl/qlc_chk.sv
module qlc_chk #(
    parameter int NLAG  = 16,
    parameter int ACC_W = 32
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    start,
    input logic                    ack,
    input logic                    auto_mode,
    input logic [7:0]              x_word,
    input logic                    busy,
    input logic                    done,
    input logic                    dump,
    input logic [7:0]              cas_y,
    input logic [$clog2(NLAG)-1:0] rd_lag,
    input logic [ACC_W-1:0]        rd_data
);
    logic pv;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pv <= 1'b0;
        else        pv <= 1'b1;
    end

    assert_start_runs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    assert_done_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !ack) |=> done);

    assert_ack_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !dump) |=> !done);

    assert_done_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pv && $rose(done)) |-> $past(busy));

    assert_buf_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pv && $stable(rd_lag) && !$past(dump)) |-> $stable(rd_data));

    assert_auto_feed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pv && $past(auto_mode)) |-> (cas_y == $past(x_word)));
endmodule

bind quad_lag_correlator qlc_chk #(.NLAG(NLAG), .ACC_W(ACC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .ack(ack), .auto_mode(auto_mode),
    .x_word(x_word), .busy(busy), .done(done), .dump(dump), .cas_y(cas_y),
    .rd_lag(rd_lag), .rd_data(rd_data)
);

// File: tb/quad_lag_correlator_bench.sv
module quad_lag_correlator_bench;
    localparam int NLAG  = 8;
    localparam int L     = NLAG / 4;
    localparam int ACC_W = 32;
    localparam int LEN_W = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] x_word = '0, y_word = '0;
    logic auto_mode = 1'b0, start = 1'b0, continuous = 1'b0, ack = 1'b0;
    logic [LEN_W-1:0] int_len = '0;
    logic [$clog2(NLAG)-1:0] rd_lag = '0;
    logic [ACC_W-1:0] rd_data, rd_data2;
    logic busy, done, busy2, done2;
    logic [7:0] cas_x, cas_y, cas_x2, cas_y2;

    int n_chk = 0, n_bad = 0;
    int ec = 0;
    int pat = 0;
    logic [7:0] cx = '0, cy = '0;
    logic [31:0] rs = 32'h1234_5678;
    logic [7:0] xw [8192];
    logic [7:0] yw [8192];

    always #4 clk = ~clk;

    quad_lag_correlator #(.NLAG(NLAG), .ACC_W(ACC_W), .LEN_W(LEN_W)) u_quad_lag_correlator (
        .clk(clk), .rst_n(rst_n), .x_word(x_word), .y_word(y_word), .auto_mode(auto_mode),
        .int_len(int_len), .start(start), .continuous(continuous), .ack(ack),
        .rd_lag(rd_lag), .rd_data(rd_data), .busy(busy), .done(done),
        .cas_x(cas_x), .cas_y(cas_y));

    quad_lag_correlator #(.NLAG(NLAG), .ACC_W(ACC_W), .LEN_W(LEN_W)) u_casc (
        .clk(clk), .rst_n(rst_n), .x_word(cas_x), .y_word(cas_y), .auto_mode(1'b0),
        .int_len(int_len), .start(start), .continuous(continuous), .ack(ack),
        .rd_lag(rd_lag), .rd_data(rd_data2), .busy(busy2), .done(done2),
        .cas_x(cas_x2), .cas_y(cas_y2));

    always @(posedge clk) begin
        xw[ec] = x_word;
        yw[ec] = auto_mode ? x_word : y_word;
        ec <= ec + 1;
    end

    always @(negedge clk) begin
        if (pat == 0) begin
            x_word = cx;
            y_word = cy;
        end else begin
            rs = rs ^ (rs << 13);
            rs = rs ^ (rs >> 17);
            rs = rs ^ (rs << 5);
            x_word = rs[7:0];
            y_word = rs[19:12];
        end
    end

    function automatic longint wt(input logic [7:0] w, input int j);
        int c;
        c = int'(w[2*j +: 2]);
        return longint'(2*c - 3);
    endfunction

    function automatic longint model(input int k, input int e0, input int len, input int sh);
        longint acc;
        acc = 0;
        for (int e = e0 + 1; e <= e0 + len; e++) begin
            int n;
            n = e - L - 1 - sh;
            for (int j = 0; j < 4; j++) begin
                int s, t;
                s = 4*n + j;
                t = s + k;
                acc += wt(xw[s/4], s%4) * wt(yw[t/4], t%4);
            end
        end
        return acc;
    endfunction

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic do_start(input int len, input logic cont, output int e0);
        int_len = LEN_W'(len);
        continuous = cont;
        start = 1'b1;
        e0 = ec;
        step();
        start = 1'b0;
    endtask

    task automatic do_ack();
        ack = 1'b1;
        step();
        ack = 1'b0;
    endtask

    task automatic wait_dump(input string tag, input int e_dump);
        while (ec < e_dump) step();
        chk({tag, " done low before dump"}, longint'(done), 0);
        step();
        chk({tag, " done high after dump"}, longint'(done), 1);
    endtask

    task automatic check_lags(input string tag, input int e0, input int len);
        for (int k = 0; k < NLAG; k++) begin
            rd_lag = k[$clog2(NLAG)-1:0];
            #1;
            chk($sformatf("%s lag %0d", tag, k), longint'($signed(rd_data)), model(k, e0, len, 0));
        end
    endtask

    task automatic t_reset();
        chk("R9 busy after reset", longint'(busy), 0);
        chk("R9 done after reset", longint'(done), 0);
        rd_lag = '0; #1;
        chk("R9 lag0 after reset", longint'($signed(rd_data)), 0);
        rd_lag = NLAG - 1; #1;
        chk("R9 last lag after reset", longint'($signed(rd_data)), 0);
    endtask

    task automatic t_const();
        int e0;
        pat = 0; cx = 8'hFF; cy = 8'h00; auto_mode = 1'b0;
        steps(L + 4);
        do_start(5, 1'b0, e0);
        wait_dump("R1 const", e0 + 5);
        for (int k = 0; k < NLAG; k++) begin
            rd_lag = k[$clog2(NLAG)-1:0]; #1;
            chk($sformatf("R1 +3x-3 lag %0d", k), longint'($signed(rd_data)), -180);
        end
        do_ack();
        cx = 8'd79; cy = 8'hFF;
        steps(L + 4);
        do_start(4, 1'b0, e0);
        wait_dump("R1 packed", e0 + 4);
        rd_lag = 0; #1;
        chk("R1 word 79 vs +3 lag0", longint'($signed(rd_data)), 24);
        check_lags("R1 word 79", e0, 4);
        do_ack();
    endtask

    task automatic t_random();
        int e0;
        pat = 1; auto_mode = 1'b0;
        steps(4);
        do_start(20, 1'b0, e0);
        wait_dump("R2 random", e0 + 20);
        check_lags("R2 random", e0, 20);
        for (int k = 0; k < NLAG; k++) begin
            rd_lag = k[$clog2(NLAG)-1:0]; #1;
            chk($sformatf("R8 cascade lag %0d", NLAG + k), longint'($signed(rd_data2)),
                model(NLAG + k, e0, 20, L + 1));
        end
        chk("R3 busy low after single shot", longint'(busy), 0);
        do_ack();
        chk("R6 done cleared by ack", longint'(done), 0);
    endtask

    task automatic t_len1();
        int e0;
        do_start(1, 1'b0, e0);
        wait_dump("R3 len1", e0 + 1);
        check_lags("R3 len1", e0, 1);
        do_ack();
    endtask

    task automatic t_auto();
        int e0;
        auto_mode = 1'b1;
        steps(L + 3);
        do_start(12, 1'b0, e0);
        wait_dump("R7 auto", e0 + 12);
        check_lags("R7 auto", e0, 12);
        chk("R7 cas_y follows x", longint'(cas_y), longint'(xw[ec-1]));
        do_ack();
        auto_mode = 1'b0;
        steps(L + 3);
    endtask

    task automatic t_cont();
        int e0, e1;
        do_start(24, 1'b1, e0);
        wait_dump("R5 first", e0 + 24);
        do_ack();
        check_lags("R5 first", e0, 24);
        e1 = e0 + 24;
        wait_dump("R5 second", e1 + 24);
        check_lags("R5 second", e1, 24);
        chk("R5 still running", longint'(busy), 1);
        continuous = 1'b0;
        do_ack();
        while (busy) step();
        do_ack();
    endtask

    task automatic t_hold();
        int e0;
        longint keep0, keep5;
        do_start(10, 1'b0, e0);
        steps(3);
        start = 1'b1; step(); start = 1'b0;
        wait_dump("R3 start ignored while running", e0 + 10);
        check_lags("R3 restart ignored", e0, 10);
        rd_lag = 0; #1; keep0 = longint'($signed(rd_data));
        rd_lag = 5; #1; keep5 = longint'($signed(rd_data));
        cx = 8'hAA; cy = 8'h33; pat = 0;
        steps(12);
        chk("R6 done held without ack", longint'(done), 1);
        chk("R4 busy low while holding", longint'(busy), 0);
        rd_lag = 0; #1;
        chk("R4 lag0 held", longint'($signed(rd_data)), keep0);
        rd_lag = 5; #1;
        chk("R4 lag5 held", longint'($signed(rd_data)), keep5);
        do_ack();
        chk("R6 done low after ack", longint'(done), 0);
    endtask

    task automatic t_casports();
        pat = 1;
        steps(L + 5);
        for (int i = 0; i < 4; i++) begin
            chk("R8 cas_x delay", longint'(cas_x), longint'(xw[ec-1-L]));
            chk("R8 cas_y word", longint'(cas_y), longint'(yw[ec-1]));
            step();
        end
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        steps(4);
        rst_n = 1'b1;
        step();
        t_reset();
        t_const();
        t_random();
        t_len1();
        t_auto();
        t_cont();
        t_hold();
        t_casports();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule